// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is a single bus-master DMA channel for a disk controller. Software fills a table of descriptors in memory, each naming a memory region and a byte length. It then programs the table pointer into an 8-byte register window and, after the drive has been given its command, sets the start bit. The channel fetches descriptors in turn and moves 32-bit words between memory and the drive-side data streams until it finishes the descriptor marked as last.

The channel halts early if software clears the start bit or if memory answers with an error. The drive's interrupt line is latched into a status flag. Software clears that flag, and the error flag, by writing a one to it. A finished transfer is recognised by the low three status bits reading 100b: idle, no error, interrupt seen.

Top module: `bm_dma_channel`

## Requirements
- R1: Register window, one byte per access. Offset 0 is the command byte: bit 0 is start, bit 3 is direction, and the other bits read 0. Offset 2 is status. Offsets 4 to 7 hold the table pointer, least significant byte first. Offsets 1 and 3 read 0 and ignore writes. All registers reset to 0.
- R2: The two low bits of the table pointer always read 0.
- R3: A write that changes start from 0 to 1 begins the walk at the table pointer, and status bit 0 (active) reads 1 from then on. A write of 1 while start is already 1 does not restart the walk.
- R4: A descriptor is two words. The word at P is the data address. In the word at P+4, bits 15:0 are the byte count (0 means 65536) and bit 31 marks the last entry. The next descriptor is at P+8.
- R5: A descriptor moves ceil(count/4) words, at consecutive word addresses starting from its data address (low two address bits ignored). Each descriptor therefore costs 2 + ceil(count/4) memory accesses.
- R6: With direction 1, words taken from the receive stream are written to memory in order. With direction 0, words read from memory are offered on the transmit stream in order.
- R7: A write to the direction bit is ignored while active is 1.
- R8: When the last descriptor's final word is moved, active returns to 0 and no further memory or stream activity occurs.
- R9: Clearing start stops the walk at the next word boundary: active clears, no new memory request or stream word follows, and the pointer and status bits 5 and 6 keep their values.
- R10: An error response from memory sets status bit 1, clears active and halts the walk.
- R11: The device interrupt input sets status bit 2. Writing 1 to status bit 1 or bit 2 clears it, and a set in the same cycle wins over the clear. Status bits 5 and 6 are plain read/write bits. Status bits 3, 4 and 7 read 0. A completed transfer followed by an interrupt reads 100b in status bits 2:0.
- R12: Receive data already offered before start is set is taken without loss, beginning with its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Memory access failed |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| rx_valid | input | 1 | Drive has a word for memory |
| rx_data | input | 32 | Word from the drive |
| rx_ready | output | 1 | Channel takes the receive word |
| tx_valid | output | 1 | Channel offers a word to the drive |
| tx_data | output | 32 | Word to the drive |
| tx_ready | input | 1 | Drive takes the transmit word |
| dev_irq | input | 1 | Drive interrupt request |

## Verification
A wrong walk state shows up at the memory port within one access. Examples are a skipped descriptor, a miscounted tail word or an ignored last mark: the access count and the addresses differ from 2 + ceil(count/4) per descriptor, and the stored or transmitted words arrive out of order or go missing. Flag faults (a lost write-one-to-clear, a clear that beats a set, an active bit that survives an abort or an error) are visible on the next status read, two cycles after the event at most. Descriptor-count corners (odd byte counts, the zero-means-64K case, chained tables) are each compared against an independently counted access total.

// File: rtl/bm_dma_channel.sv
module bm_dma_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        rx_valid,
  input  logic [31:0] rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  input  logic        tx_ready,
  input  logic        dev_irq
);
  localparam int CNT_W  = 16;
  localparam int WORD_W = CNT_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_DADDR, S_DCNT, S_RX, S_MWR, S_MRD, S_TX} st_t;

  st_t         st, adv_st;
  logic        start, dir, err_f, irq_f;
  logic [1:0]  cap;
  logic [29:0] base, dptr, waddr;
  logic [WORD_W-1:0] left;
  logic        last;
  logic [31:0] buf_q;

  wire busy     = (st != S_IDLE);
  wire wr_cmd   = reg_wr && (reg_addr == 3'd0);
  wire wr_st    = reg_wr && (reg_addr == 3'd2);
  wire go       = wr_cmd && reg_wdata[0] && !start;
  wire mem_st   = (st == S_DADDR) || (st == S_DCNT) || (st == S_MWR) || (st == S_MRD);
  wire [CNT_W:0] cnt_ext = (mem_rdata[CNT_W-1:0] == '0) ? {1'b1, {CNT_W{1'b0}}}
                                                       : {1'b0, mem_rdata[CNT_W-1:0]};
  wire [CNT_W:0] cnt_rnd = cnt_ext + 3;
  wire tx_take  = (st == S_TX) && start && tx_ready;

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[30:CNT_W], cnt_rnd[1:0]};

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b0; dir <= 1'b0; err_f <= 1'b0; irq_f <= 1'b0;
      cap <= 2'b00; base <= '0;
    end else begin
      if (wr_cmd) begin
        start <= reg_wdata[0];
        if (!busy) dir <= reg_wdata[3];
      end
      if (wr_st) cap <= reg_wdata[6:5];
      err_f <= (err_f && !(wr_st && reg_wdata[1])) || (mem_st && mem_err);
      irq_f <= (irq_f && !(wr_st && reg_wdata[2])) || dev_irq;
      if (reg_wr) begin
        case (reg_addr)
          3'd4: base[5:0]   <= reg_wdata[7:2];
          3'd5: base[13:6]  <= reg_wdata;
          3'd6: base[21:14] <= reg_wdata;
          3'd7: base[29:22] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {4'b0, dir, 2'b0, start};
      3'd2: reg_rdata = {1'b0, cap, 2'b0, irq_f, err_f, busy};
      3'd4: reg_rdata = {base[5:0], 2'b00};
      3'd5: reg_rdata = base[13:6];
      3'd6: reg_rdata = base[21:14];
      3'd7: reg_rdata = base[29:22];
      default: reg_rdata = 8'h00;
    endcase
  end

  // state after one data word has been moved
  always_comb begin
    if (!start)                 adv_st = S_IDLE;
    else if (left == 1 && last) adv_st = S_IDLE;
    else if (left == 1)         adv_st = S_DADDR;
    else                        adv_st = dir ? S_RX : S_MRD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dptr <= '0; waddr <= '0; left <= '0; last <= 1'b0; buf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin st <= S_DADDR; dptr <= base; end
        S_DADDR:
          if (mem_err) st <= S_IDLE;
          else if (mem_ack) begin
            waddr <= mem_rdata[31:2];
            st    <= start ? S_DCNT : S_IDLE;
          end
        S_DCNT:
          if (mem_err) st <= S_IDLE;
          else if (mem_ack) begin
            left <= cnt_rnd[CNT_W:2];
            last <= mem_rdata[31];
            st   <= !start ? S_IDLE : (dir ? S_RX : S_MRD);
          end
        S_RX:
          if (!start) st <= S_IDLE;
          else if (rx_valid) begin buf_q <= rx_data; st <= S_MWR; end
        S_MRD:
          if (mem_err) st <= S_IDLE;
          else if (mem_ack) begin buf_q <= mem_rdata; st <= start ? S_TX : S_IDLE; end
        S_MWR, S_TX:
          if (st == S_MWR && mem_err) st <= S_IDLE;
          else if (st == S_TX && !start) st <= S_IDLE;
          else if ((st == S_MWR && mem_ack) || tx_take) begin
            left  <= left - 1'b1;
            waddr <= waddr + 1'b1;
            if (left == 1) dptr <= dptr + 30'd2;
            st <= adv_st;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = mem_st;
  assign mem_we    = (st == S_MWR);
  assign mem_addr  = (st == S_DADDR) ? {dptr, 2'b00} :
                     (st == S_DCNT)  ? {dptr, 2'b00} + 32'd4 : {waddr, 2'b00};
  assign mem_wdata = buf_q;
  assign rx_ready  = (st == S_RX) && start;
  assign tx_valid  = (st == S_TX) && start;
  assign tx_data   = buf_q;

  a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dir));
  a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> (!busy && err_f));
  a_r11_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_f);
  a_r6_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && (rx_ready || tx_valid)));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rx_ready && !tx_valid));
endmodule

// File: tb/bm_dma_channel_tb.sv
module bm_dma_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [7:0] reg_wdata = 0; logic [7:0] reg_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 0, mem_err = 0; logic [31:0] mem_rdata = 0;
  logic rx_valid; logic [31:0] rx_data; logic rx_ready;
  logic tx_valid; logic [31:0] tx_data; logic tx_ready = 1;
  logic dev_irq = 0;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] tx_got [0:255];
  int n_acc = 0, tx_cnt = 0, rx_idx = 0, rx_n = 0;
  bit err_en = 0; logic [31:0] err_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_dma_channel u_dut (.*);

  function automatic logic [31:0] pat(int i);
    return (32'h1234_0000 + i * 32'h0001_0101) ^ 32'h5A;
  endfunction

  assign rx_valid = rx_idx < rx_n;
  assign rx_data  = pat(rx_idx);

  always @(posedge clk) begin
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    if (tx_valid && tx_ready) begin tx_got[tx_cnt[7:0]] <= tx_data; tx_cnt <= tx_cnt + 1; end
    if (mem_req && !mem_ack && !mem_err) begin
      if (err_en && mem_addr == err_addr) mem_err <= 1;
      else begin
        mem_ack <= 1; n_acc <= n_acc + 1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[11:2]];
      end
    end else begin mem_ack <= 0; mem_err <= 0; end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary(); $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    wr(4, p[7:0]); wr(5, p[15:8]); wr(6, p[23:16]); wr(7, p[31:24]);
  endtask

  task automatic desc(input int at, input logic [31:0] a, input logic [15:0] c, input bit lst);
    mem[at >> 2] = a; mem[(at >> 2) + 1] = {lst, 15'b0, c};
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    for (int i = 0; i < 100000; i++) begin
      rd(2, s);
      if (!s[0]) return;
    end
    chk(tag, 1, 0);
  endtask

  // [31] dir, [30:15] byte count, [14:0] expected words
  localparam logic [31:0] VEC [0:7] = '{
    {1'b1, 16'd4,  15'd1}, {1'b1, 16'd5, 15'd2}, {1'b0, 16'd8,  15'd2}, {1'b0, 16'd3, 15'd1},
    {1'b1, 16'd12, 15'd3}, {1'b0, 16'd7, 15'd2}, {1'b1, 16'd1,  15'd1}, {1'b0, 16'd16, 15'd4}};

  initial begin
    logic [7:0] s, c; int bad, base_acc;
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(0, s); chk("R1 reset command", s, 0);
    rd(2, s); chk("R1 reset status", s, 0);
    rd(5, s); chk("R1 reset pointer", s, 0);
    wr(1, 8'hFF); wr(3, 8'hFF);
    rd(1, s); chk("R1 offset 1 reads 0", s, 0);
    rd(3, s); chk("R1 offset 3 reads 0", s, 0);
    set_ptr(32'hA1B2_C3D7);
    rd(4, s); chk("R2 pointer low bits", s, 8'hD4);
    rd(7, s); chk("R1 pointer byte 7", s, 8'hA1);
    rd(6, s); chk("R1 pointer byte 6", s, 8'hB2);

    foreach (VEC[v]) begin
      bit d; int w;
      d = VEC[v][31]; w = VEC[v][14:0];
      desc(32'h10, 32'h400, VEC[v][30:15], 1); set_ptr(32'h10);
      for (int k = 0; k < 8; k++) mem[256 + k] = d ? 32'h0 : pat(k + 50);
      rx_idx = 0; rx_n = d ? w : 0; tx_cnt = 0; n_acc = 0;
      wr(0, {4'b0, d, 3'b0}); wr(0, {4'b0, d, 3'b1});
      wait_idle("R8 table walk done");
      chk("R5 access count", n_acc, w + 2);
      bad = 0;
      for (int k = 0; k < w; k++)
        if (d ? (mem[256 + k] !== pat(k)) : (tx_got[k] !== pat(k + 50))) bad++;
      chk(d ? "R6 R12 receive data to memory" : "R6 memory data to transmit", bad, 0);
      chk("R5 no extra words", d ? ((mem[256 + w] == 0) ? 1 : 0) : tx_cnt, d ? 1 : w);
      wr(0, {4'b0, d, 3'b0});
    end

    // R3: start still 1 after completion does not restart
    desc(32'h10, 32'h400, 16'd4, 1); rx_idx = 0; rx_n = 1;
    wr(0, 8'h09); wait_idle("R3 first run"); base_acc = n_acc;
    wr(0, 8'h09); repeat (20) @(negedge clk);
    rd(2, s); chk("R3 no restart on repeated start", {s[0], n_acc - base_acc}, 0);
    wr(0, 8'h08);

    // R11 success pattern and flag behaviour
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    rd(2, s); chk("R11 success reads 100b", s[2:0], 3'b100);
    wr(2, 8'h04); rd(2, s); chk("R11 irq cleared by W1C", s[2], 0);
    @(negedge clk); dev_irq = 1;
    wr(2, 8'h04); rd(2, s); chk("R11 set wins over clear", s[2], 1);
    dev_irq = 0; wr(2, 8'h04);
    wr(2, 8'hFF); rd(2, s); chk("R11 capability bits and reserved zeros", s, 8'h60);

    // R4: chained descriptors, direction 0
    desc(32'h20, 32'h400, 16'd8, 0); desc(32'h28, 32'h500, 16'd4, 1);
    mem[256] = pat(50); mem[257] = pat(51); mem[320] = pat(7);
    set_ptr(32'h20); tx_cnt = 0; n_acc = 0;
    wr(0, 8'h00); wr(0, 8'h01); wait_idle("R4 chain done");
    chk("R4 chain access count", n_acc, 7);
    chk("R4 chain word 2 from second descriptor", tx_got[2], pat(7));
    chk("R4 chain word 1", tx_got[1], pat(51));
    wr(0, 8'h00);

    // R9 and R7: stall on receive, try direction change, then abort
    desc(32'h10, 32'h400, 16'd16, 1); set_ptr(32'h10);
    rx_idx = 0; rx_n = 2; n_acc = 0;
    wr(0, 8'h08); wr(0, 8'h09); repeat (30) @(negedge clk);
    rd(2, s); chk("R9 stalled transfer active", s[0], 1);
    wr(0, 8'h01); rd(0, c); chk("R7 direction write ignored while active", c, 8'h09);
    wr(0, 8'h08); @(negedge clk);
    rd(2, s); chk("R9 abort clears active, keeps bits 5 6", s, 8'h60);
    base_acc = n_acc; rx_n = 4; repeat (20) @(negedge clk);
    chk("R9 no activity after abort", {n_acc - base_acc, rx_idx}, {32'd0, 32'd2});
    rd(4, s); chk("R9 pointer kept", s, 8'h10);

    // R10: memory error on data read
    desc(32'h10, 32'h400, 16'd8, 1); err_en = 1; err_addr = 32'h400; tx_cnt = 0;
    wr(0, 8'h00); wr(0, 8'h01); wait_idle("R10 halt");
    rd(2, s); chk("R10 error set, active clear", s[1:0], 2'b10);
    chk("R10 no words sent", tx_cnt, 0);
    wr(2, 8'h02); rd(2, s); chk("R10 error W1C", s[1], 0);
    err_en = 0; wr(0, 8'h00);

    // R4: count 0 means 65536 bytes
    desc(32'h10, 32'h400, 16'd0, 1); rx_idx = 0; rx_n = 16384; n_acc = 0;
    wr(0, 8'h08); wr(0, 8'h09); wait_idle("R4 64K done");
    chk("R4 zero count moves 16384 words", n_acc, 16386);
    wr(0, 8'h08);

    summary();
    $finish;
  end
endmodule